// File: doc/BRIEF.md
# Dual-mode watchdog and interval timer

This block holds an 8-bit up-counter that advances on ticks from a free-running prescaler. The counter runs in one of two modes. In interval mode, a wrap from 0xFF to 0x00 sets a sticky overflow flag, and that flag raises an interrupt request. In watchdog mode, the same wrap drives a dedicated overflow output as a fixed-length pulse, and the flag stays untouched. Software reaches a control/status register and the counter through a small register bus with a one-bit address. Writes land on the rising clock edge. Reads are combinational.

Software cannot set the overflow flag. It can clear it only in two steps: first it reads the register while the flag is 1, then it writes 0 to the flag bit. A small state machine with the states FLG_CLEAR, FLG_SET and FLG_ARMED tracks this. The transitions are:

- "wrap" (FLG_CLEAR to FLG_SET).
- "qualify" (FLG_SET to FLG_ARMED, on a read).
- "clear" (FLG_ARMED to FLG_CLEAR, on a write of 0 with no wrap in the same cycle).
- "disarm" (FLG_ARMED to FLG_SET, on any other write to the register).

A second machine with the states PLS_IDLE and PLS_ACTIVE times the watchdog pulse. Its transitions are:

- "fire" (PLS_IDLE to PLS_ACTIVE, on a watchdog wrap).
- "refire" (PLS_ACTIVE stays in PLS_ACTIVE and reloads, on a new wrap).
- "expire" (PLS_ACTIVE to PLS_IDLE, when the length count runs out).

Top module: `wdt_dual_timer`

## Requirements
- R1: After reset, the control/status register reads 0x18, the counter reads 0x00, and both the interrupt request and the watchdog pulse are low.
- R2: Control/status register layout (address 0):
  - bit 7 is the overflow flag;
  - bit 6 is the mode, where 1 means watchdog and 0 means interval;
  - bit 5 is the enable;
  - bits 4 and 3 always read 1;
  - bits 2..0 are the tick select.

  The mode, enable and select bits read back the value last written.
- R3: While enable is 1, the counter (address 1) advances by one on each prescaler tick. The tick period is 2, 64, 128, 512, 2048, 8192, 32768 or 131072 cycles for select values 0 to 7. While enable is 0, the counter holds its value.
- R4: In interval mode, a wrap from 0xFF to 0x00 sets the flag on that same edge. The interrupt request is high exactly while the flag is 1 and the mode is interval.
- R5: In watchdog mode, a wrap leaves the flag unchanged. The watchdog pulse output goes high in the cycle after the wrap edge and stays high for 8 cycles.
- R6: A bus write never sets the flag. A write of 0 to bit 7 clears the flag only if an earlier read returned the flag as 1. Any write to the register drops that qualification.
- R7: A bus write to the counter in the same cycle as a tick loads the written value, and the increment is lost.
- R8: If a qualified clear and an interval wrap fall in the same cycle, the flag stays set. The qualification is dropped, so a later write of 0 alone does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 counter |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, qualifies a flag clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| int_req_o | output | 1 | Interval interrupt request |
| wdog_pulse_o | output | 1 | Watchdog overflow pulse |

## Verification
The software clear of the flag and a new counter wrap can land on the same edge. A second collision is a counter write on a tick edge. The bench first finds the prescaler phase at the fastest select, by loading the counter and seeing whether it advanced one cycle later. It then loads 0xFF on a non-tick edge and issues the qualified clear on the following edge, which is a tick edge. The result is judged at the ports: the interrupt must stay high, a following plain write of 0 must leave it high, and the counter readback must show 0x00 after the wrap and the written value after a load.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 8;

    localparam logic ADDR_CSR = 1'b0;
    localparam logic ADDR_CNT = 1'b1;

    localparam int CSR_FLAG_BIT = 7;
    localparam int CSR_MODE_BIT = 6;
    localparam int CSR_EN_BIT   = 5;
    localparam int SEL_W        = 3;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flag_state_t;

    typedef enum logic {
        PLS_IDLE   = 1'b0,
        PLS_ACTIVE = 1'b1
    } pulse_state_t;

    // log2 of the tick period for each select value
    function automatic int tap_exp(input int sel);
        case (sel)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 9;
            4:       return 11;
            5:       return 13;
            6:       return 15;
            default: return 17;
        endcase
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NUM_TAPS = 1 << SEL_W;

    logic [DIV_W-1:0]    div_q;
    logic [NUM_TAPS-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // one tap per select: tick when the low bits are all ones
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int E = tap_exp(g);
        assign hit[g] = &div_q[E-1:0];
    end

    assign tick = hit[sel];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic step;
    assign step = en && tick && !load;
    assign wrap = step && (cnt == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdt_flag_fsm.sv
module wdt_flag_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_iv,
    input  logic csr_rd,
    input  logic csr_wr,
    input  logic wr_flag_bit,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (wrap_iv) state_d = FLG_SET;                      // wrap
            FLG_SET:   if (csr_rd && !csr_wr) state_d = FLG_ARMED;          // qualify
            FLG_ARMED: if (csr_wr) begin
                if (!wr_flag_bit && !wrap_iv) state_d = FLG_CLEAR;          // clear
                else                          state_d = FLG_SET;            // disarm
            end
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
    end
endmodule

// File: rtl/wdt_pulse_fsm.sv
module wdt_pulse_fsm
    import wdt_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    localparam int LW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [LW-1:0] LAST = LW'(LEN - 1);

    pulse_state_t state_q, state_d;
    logic [LW-1:0] left_q, left_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PLS_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            PLS_IDLE: if (fire) begin                      // fire
                state_d = PLS_ACTIVE;
                left_d  = LAST;
            end
            PLS_ACTIVE: begin
                if (fire) left_d = LAST;                   // refire
                else if (left_q == '0) state_d = PLS_IDLE; // expire
                else left_d = left_q - 1'b1;
            end
            default: state_d = PLS_IDLE;
        endcase
    end

    always_comb begin
        pulse = (state_q == PLS_ACTIVE);
    end
endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer
    import wdt_pkg::*;
#(
    parameter int DIV_W     = 17,
    parameter int PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              int_req_o,
    output logic              wdog_pulse_o
);
    logic             mode_q;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             tick;
    logic             cnt_wr;
    logic             csr_wr;
    logic             csr_rd;
    logic [DATA_W-1:0] cnt_q;
    logic             wrap_evt;
    logic             flag;

    assign csr_wr = bus_wr && (bus_addr == ADDR_CSR);
    assign csr_rd = bus_rd && (bus_addr == ADDR_CSR);
    assign cnt_wr = bus_wr && (bus_addr == ADDR_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            en_q   <= 1'b0;
            sel_q  <= '0;
        end else if (csr_wr) begin
            mode_q <= bus_wdata[CSR_MODE_BIT];
            en_q   <= bus_wdata[CSR_EN_BIT];
            sel_q  <= bus_wdata[SEL_W-1:0];
        end
    end

    wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .sel(sel_q), .tick(tick)
    );

    wdt_counter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick),
        .load(cnt_wr), .load_val(bus_wdata), .cnt(cnt_q), .wrap(wrap_evt)
    );

    wdt_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .wrap_iv(wrap_evt && !mode_q),
        .csr_rd(csr_rd), .csr_wr(csr_wr),
        .wr_flag_bit(bus_wdata[CSR_FLAG_BIT]), .flag(flag)
    );

    wdt_pulse_fsm #(.LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .fire(wrap_evt && mode_q), .pulse(wdog_pulse_o)
    );

    always_comb begin
        if (bus_addr == ADDR_CNT) bus_rdata = cnt_q;
        else                      bus_rdata = {flag, mode_q, en_q, 2'b11, sel_q};
    end

    assign int_req_o = flag && !mode_q;
endmodule

// File: rtl/wdt_dual_timer_chk.sv
module wdt_dual_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] cnt_q,
    input logic       en_q,
    input logic       tick,
    input logic       wrap_evt,
    input logic       mode_q,
    input logic       flag,
    input logic       wdog_pulse_o
);
    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && tick && !cnt_wr) |=> (cnt_q == 8'($past(cnt_q) + 8'd1)));

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_wr) |=> $stable(cnt_q));

    p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !mode_q) |=> flag);

    p_wd_fires_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && mode_q) |=> wdog_pulse_o);

    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(wrap_evt && !mode_q)) |=> !flag);

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(bus_wdata)));

    p_race_keeps_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wrap_evt && !mode_q) |=> flag);
endmodule

bind wdt_dual_timer wdt_dual_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .bus_wdata(bus_wdata),
    .cnt_q(cnt_q), .en_q(en_q), .tick(tick), .wrap_evt(wrap_evt),
    .mode_q(mode_q), .flag(flag), .wdog_pulse_o(wdog_pulse_o)
);

// File: tb/wdt_dual_timer_tb_top.sv
module wdt_dual_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       int_req_o;
    logic       wdog_pulse_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    int par = 0;

    localparam logic CSR = 1'b0;
    localparam logic CNT = 1'b1;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_dual_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .int_req_o(int_req_o), .wdog_pulse_o(wdog_pulse_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // all bus tasks start and end at a falling edge
    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int e, run, seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CSR, v); chk("R1 csr", v, 8'h18);
        rd(CNT, v); chk("R1 cnt", v, 8'h00);
        chk("R1 irq", int_req_o, 0);
        chk("R1 wdog", wdog_pulse_o, 0);

        // R2 field sweep with enable off
        for (int s = 0; s < 8; s++) begin
            wr(CSR, 8'(s));
            rd(CSR, v); chk("R2 sel", v, 8'h18 | s);
        end
        wr(CSR, 8'h47); rd(CSR, v); chk("R2 mode", v, 8'h5F);
        wr(CSR, 8'h00); rd(CSR, v); chk("R2 clear fields", v, 8'h18);

        // R3 tick periods: m*period cycles after a load give exactly m steps
        for (int s = 0; s < 7; s++) begin
            int m, per;
            per = 1 << ((s == 0) ? 1 : (s == 1) ? 6 : (s == 2) ? 7 : 9 + 2 * (s - 3));
            m = (s < 5) ? 3 : (s == 5) ? 2 : 1;
            wr(CSR, 8'h20 | 8'(s));
            wr(CNT, 8'h00);
            repeat (m * per) @(negedge clk);
            rd(CNT, v); chk($sformatf("R3 period sel%0d", s), v, m);
        end
        wr(CSR, 8'h00); wr(CNT, 8'h40);
        repeat (200) @(negedge clk);
        rd(CNT, v); chk("R3 hold when disabled", v, 8'h40);

        // tick phase at select 0
        wr(CSR, 8'h20);
        wr(CNT, 8'h10); e = cyc;
        @(negedge clk);
        rd(CNT, v);
        par = (v == 8'h11) ? (e + 1) % 2 : e % 2;

        // R4 interval wrap
        wr(CNT, 8'hFF);
        repeat (2) @(negedge clk);
        chk("R4 irq after wrap", int_req_o, 1);
        chk("R4 wdog quiet", wdog_pulse_o, 0);
        rd(CNT, v); chk("R4 wrapped to 0", v, 8'h00);

        // R6 clear protocol
        wr(CSR, 8'h00);
        chk("R6 unqualified clear", int_req_o, 1);
        rd(CSR, v); chk("R6 read flag", v, 8'h98);
        wr(CSR, 8'h80);
        chk("R6 write one keeps", int_req_o, 1);
        wr(CSR, 8'h00);
        chk("R6 qualification dropped", int_req_o, 1);
        rd(CSR, v); wr(CSR, 8'h00);
        chk("R6 qualified clear", int_req_o, 0);
        rd(CSR, v); chk("R6 flag cleared", v, 8'h18);
        wr(CSR, 8'h80); rd(CSR, v); chk("R6 no sw set", v, 8'h18);

        // R4 mode gates the request
        wr(CSR, 8'h20); wr(CNT, 8'hFF);
        repeat (2) @(negedge clk);
        wr(CSR, 8'h40);
        chk("R4 irq off in watchdog mode", int_req_o, 0);
        rd(CSR, v); chk("R4 flag kept", v, 8'hD8);
        rd(CSR, v); wr(CSR, 8'h00);
        chk("R4 flag cleared", int_req_o, 0);

        // R5 watchdog pulse
        wr(CSR, 8'h60); wr(CNT, 8'hFF);
        seen = 0; run = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (wdog_pulse_o) begin seen = 1; run++; end
            @(negedge clk);
        end
        chk("R5 pulse seen", seen, 1);
        chk("R5 pulse length", run, 8);
        chk("R5 no irq", int_req_o, 0);
        rd(CSR, v); chk("R5 flag untouched", v, 8'h78);
        wr(CSR, 8'h00);

        // R7 load on a tick edge
        wr(CSR, 8'h20);
        if ((cyc + 1) % 2 != par) @(negedge clk);
        wr(CNT, 8'h33);
        rd(CNT, v); chk("R7 load wins", v, 8'h33);
        rd(CNT, v); chk("R7 no step off tick", v, 8'h33);
        rd(CNT, v); chk("R7 step resumes", v, 8'h34);

        // R8 qualified clear racing a wrap
        wr(CNT, 8'hFF);
        repeat (2) @(negedge clk);
        rd(CSR, v); chk("R8 flag set", v, 8'hB8);
        if ((cyc + 1) % 2 == par) @(negedge clk);
        wr(CNT, 8'hFF);
        wr(CSR, 8'h20);
        chk("R8 flag kept on race", int_req_o, 1);
        rd(CNT, v); chk("R8 wrap happened", v, 8'h00);
        wr(CSR, 8'h20);
        chk("R8 qualification discarded", int_req_o, 1);
        rd(CSR, v); wr(CSR, 8'h00);
        chk("R8 later clear", int_req_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule